// File: doc/BRIEF.md
# DMA Channel Event Scheduler

The scheduler sits in front of a DMA transfer engine and decides, one trigger at a time, what each of a few channels should ask that engine to do. Each channel keeps a parameter set: an element count per array, an array count per frame, a frame count, a flag that picks between per-array and per-frame servicing, and an optional link to another channel. A channel can be triggered in three ways: by its external event line, by a manual set pulse, or by the completion of a transfer on a channel that links to it.

Every trigger marks the channel pending. Each cycle, the lowest-numbered pending channel is examined. Its set is classified as null (every count zero), dummy (some counts zero, others not) or valid. A valid set yields one request, covering either a single array or a whole frame, and its remaining counts are stepped down. A dummy set yields a marked dummy request. A null set yields no request and raises the error interrupt. Requests wait in an in-order queue until the engine accepts them.

The engine reports completions back. A completion flagged as final pulses the per-channel completion interrupt. Any completion on a channel that links to another triggers the linked channel.

Top module: `dma_evt_sched`

## Requirements
- R1: After reset the queue is empty (`rq_valid` low), and `err_int`, `cmp_int` and `miss_flag` are all zero.
- R2: A one-cycle pulse on `man_set[i]` or `ev_in[i]`, sampled at a clock edge, makes the channel pending. The request for it becomes visible at the output after the next edge, provided the queue has room.
- R3: When several channels are pending, the lowest-numbered one is serviced first, one per cycle. The others stay pending and are serviced in later cycles.
- R4: In frame mode (`cfg_ab`=1), each trigger of a valid set issues a request with `rq_kind`=1, `rq_acnt`=element count and `rq_bcnt`=programmed array count, and decrements the frame count. `rq_last`=1 when the frame count was 1 before the decrement.
- R5: In array mode (`cfg_ab`=0), each trigger of a valid set issues a request with `rq_kind`=0, `rq_acnt`=element count and `rq_bcnt`=1. The remaining array count steps down; when it reaches the end of a frame, it is reloaded and the frame count decrements. `rq_last`=1 only for the final array of the final frame.
- R6: A set with all three counts zero issues no request, and `err_int` is high for exactly one cycle, after the edge at which the set is examined.
- R7: A set with at least one count zero and at least one count nonzero issues a request with `rq_kind`=2 and `rq_last`=0, and does not raise `err_int`.
- R8: The queue holds 16 requests and delivers them in order. While it is full, a pending trigger is held and issued once space frees. A queued request stays stable while `rq_ready` is low.
- R9: A trigger that arrives while the same channel is still pending and is not being serviced in that cycle sets the sticky bit `miss_flag[i]` and pulses `err_int`. A configuration write to that channel clears the bit.
- R10: A completion with `cmp_last`=1 on channel `c` makes `cmp_int` equal to the one-hot value of `c` for one cycle after the edge.
- R11: A completion on a channel whose link is enabled triggers the linked channel as if by a manual set at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write a parameter set |
| cfg_ch | input | CHW | Channel written |
| cfg_acnt | input | CW | Element count per array |
| cfg_bcnt | input | CW | Array count per frame |
| cfg_ccnt | input | CW | Frame count |
| cfg_ab | input | 1 | 1 = frame per trigger, 0 = array per trigger |
| cfg_link_en | input | 1 | Enable completion linking |
| cfg_link_ch | input | CHW | Channel triggered on completion |
| ev_in | input | NCH | External event pulses |
| man_set | input | NCH | Manual trigger pulses |
| rq_valid | output | 1 | Queue head valid |
| rq_ready | input | 1 | Engine accepts the head |
| rq_ch | output | CHW | Requesting channel |
| rq_kind | output | 2 | 0 array, 1 frame, 2 dummy |
| rq_last | output | 1 | Final slice of the set |
| rq_acnt | output | CW | Elements per array |
| rq_bcnt | output | CW | Arrays in this request |
| cmp_valid | input | 1 | Completion report |
| cmp_ch | input | CHW | Channel completed |
| cmp_last | input | 1 | Completion was the final slice |
| cmp_int | output | NCH | Completion interrupt pulses |
| err_int | output | 1 | Error interrupt pulse |
| miss_flag | output | NCH | Sticky missed-trigger flags |

## Verification
A trigger driven before edge E0 makes the channel pending at E0. Its request is pushed at E1 and is visible at the queue head after E1. The bench drives inputs on falling edges, and its scoreboard monitor compares every accepted head at the falling edge before the pop edge, so each request is checked in order rather than at a fixed cycle. An error from a null set is sampled one falling edge after the trigger task returns, because it is registered at E1. An error from a missed trigger, and the completion interrupt, are registered at the edge that sees the stimulus, so they are sampled at the very next falling edge.

// File: rtl/dma_evt_sched.sv
module dma_evt_sched #(
  parameter int NCH = 4,
  parameter int CW  = 8,
  parameter int QD  = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CHW-1:0] cfg_ch,
  input  logic [CW-1:0]  cfg_acnt,
  input  logic [CW-1:0]  cfg_bcnt,
  input  logic [CW-1:0]  cfg_ccnt,
  input  logic           cfg_ab,
  input  logic           cfg_link_en,
  input  logic [CHW-1:0] cfg_link_ch,
  input  logic [NCH-1:0] ev_in,
  input  logic [NCH-1:0] man_set,
  output logic           rq_valid,
  input  logic           rq_ready,
  output logic [CHW-1:0] rq_ch,
  output logic [1:0]     rq_kind,
  output logic           rq_last,
  output logic [CW-1:0]  rq_acnt,
  output logic [CW-1:0]  rq_bcnt,
  input  logic           cmp_valid,
  input  logic [CHW-1:0] cmp_ch,
  input  logic           cmp_last,
  output logic [NCH-1:0] cmp_int,
  output logic           err_int,
  output logic [NCH-1:0] miss_flag
);
  localparam int QAW = (QD > 1) ? $clog2(QD) : 1;
  localparam int EW  = CHW + 3 + 2 * CW;

  logic [CW-1:0]  a_q [NCH];
  logic [CW-1:0]  b_q [NCH];
  logic [CW-1:0]  brl_q [NCH];
  logic [CW-1:0]  c_q [NCH];
  logic [CHW-1:0] lnk_q [NCH];
  logic [NCH-1:0] ab_q, lnk_en_q, pend_q, miss_q;

  logic [EW-1:0]  mem [QD];
  logic [QAW-1:0] wp, rp;
  logic [QAW:0]   q_cnt;

  logic [NCH-1:0] link_vec, trig, svc, miss_now, cfg_clr;
  logic [CHW-1:0] sel;
  logic           q_full, sel_vld, push, pop;
  logic           z_a, z_b, z_c, is_null, is_dummy, s_last;
  logic [1:0]     s_kind;
  logic [CW-1:0]  s_bc;

  always_comb begin
    link_vec = '0;
    if (cmp_valid && lnk_en_q[cmp_ch]) link_vec[lnk_q[cmp_ch]] = 1'b1;
  end

  always_comb begin
    sel = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (pend_q[i]) sel = CHW'(i);
  end

  assign trig    = ev_in | man_set | link_vec;
  assign q_full  = (q_cnt == (QAW+1)'(QD));
  assign sel_vld = (|pend_q) && !q_full;
  assign svc     = sel_vld ? (NCH'(1) << sel) : '0;
  assign miss_now = pend_q & ~svc & trig;
  assign cfg_clr = cfg_we ? (NCH'(1) << cfg_ch) : '0;

  assign z_a      = (a_q[sel] == '0);
  assign z_b      = (b_q[sel] == '0);
  assign z_c      = (c_q[sel] == '0);
  assign is_null  = z_a && z_b && z_c;
  assign is_dummy = (z_a || z_b || z_c) && !is_null;
  assign s_kind   = is_dummy ? 2'd2 : (ab_q[sel] ? 2'd1 : 2'd0);
  assign s_bc     = ab_q[sel] ? brl_q[sel] : CW'(1);
  assign s_last   = !is_dummy && (c_q[sel] == CW'(1)) &&
                    (ab_q[sel] || (b_q[sel] == CW'(1)));
  assign push     = sel_vld && !is_null;
  assign pop      = rq_valid && rq_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= '0;
      miss_q   <= '0;
      ab_q     <= '0;
      lnk_en_q <= '0;
      err_int  <= 1'b0;
      cmp_int  <= '0;
      for (int i = 0; i < NCH; i++) begin
        a_q[i]   <= '0;
        b_q[i]   <= '0;
        brl_q[i] <= '0;
        c_q[i]   <= '0;
        lnk_q[i] <= '0;
      end
    end else begin
      pend_q  <= (pend_q & ~svc) | trig;
      miss_q  <= (miss_q | miss_now) & ~cfg_clr;
      err_int <= (sel_vld && is_null) || (|miss_now);
      cmp_int <= (cmp_valid && cmp_last) ? (NCH'(1) << cmp_ch) : '0;
      if (sel_vld && !is_null && !is_dummy) begin
        if (ab_q[sel]) begin
          c_q[sel] <= c_q[sel] - 1'b1;
        end else if (b_q[sel] == CW'(1)) begin
          b_q[sel] <= brl_q[sel];
          c_q[sel] <= c_q[sel] - 1'b1;
        end else begin
          b_q[sel] <= b_q[sel] - 1'b1;
        end
      end
      if (cfg_we) begin
        a_q[cfg_ch]      <= cfg_acnt;
        b_q[cfg_ch]      <= cfg_bcnt;
        brl_q[cfg_ch]    <= cfg_bcnt;
        c_q[cfg_ch]      <= cfg_ccnt;
        ab_q[cfg_ch]     <= cfg_ab;
        lnk_en_q[cfg_ch] <= cfg_link_en;
        lnk_q[cfg_ch]    <= cfg_link_ch;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      q_cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      q_cnt <= q_cnt + (QAW+1)'(push) - (QAW+1)'(pop);
    end
  end

  always_ff @(posedge clk)
    if (push) mem[wp] <= {sel, s_kind, s_last, a_q[sel], s_bc};

  assign rq_valid = (q_cnt != '0);
  assign {rq_ch, rq_kind, rq_last, rq_acnt, rq_bcnt} = mem[rp];
  assign miss_flag = miss_q;
endmodule

// File: rtl/dma_evt_sched_chk.sv
module dma_evt_sched_chk #(
  parameter int NCH = 4,
  parameter int CW  = 8,
  parameter int QD  = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int QAW = (QD > 1) ? $clog2(QD) : 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           rq_valid,
  input logic           rq_ready,
  input logic [CHW-1:0] rq_ch,
  input logic [1:0]     rq_kind,
  input logic           rq_last,
  input logic [CW-1:0]  rq_acnt,
  input logic [CW-1:0]  rq_bcnt,
  input logic           cmp_valid,
  input logic           cmp_last,
  input logic [NCH-1:0] cmp_int,
  input logic           err_int,
  input logic [NCH-1:0] miss_flag,
  input logic [QAW:0]   q_cnt
);
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= (QAW+1)'(QD));

  a_r8_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid && !rq_ready |=> rq_valid &&
      $stable({rq_ch, rq_kind, rq_last, rq_acnt, rq_bcnt}));

  a_r10_cmp_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmp_int));

  a_r10_cmp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && cmp_last |=> cmp_int != '0);

  a_r9_miss_err: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_flag & ~$past(miss_flag)) != '0 |-> err_int);

  a_r7_dummy_not_last: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid && rq_kind == 2'd2 |-> !rq_last);
endmodule

bind dma_evt_sched dma_evt_sched_chk #(.NCH(NCH), .CW(CW), .QD(QD)) u_chk (
  .clk(clk), .rst_n(rst_n), .rq_valid(rq_valid), .rq_ready(rq_ready),
  .rq_ch(rq_ch), .rq_kind(rq_kind), .rq_last(rq_last), .rq_acnt(rq_acnt),
  .rq_bcnt(rq_bcnt), .cmp_valid(cmp_valid), .cmp_last(cmp_last),
  .cmp_int(cmp_int), .err_int(err_int), .miss_flag(miss_flag), .q_cnt(q_cnt)
);

// File: tb/test_dma_evt_sched.sv
`timescale 1ns/1ps
module test_dma_evt_sched;
  localparam int NCH = 4, CW = 8, CHW = 2, EW = CHW + 3 + 2 * CW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_ab = 0, cfg_link_en = 0;
  logic [CHW-1:0] cfg_ch = '0, cfg_link_ch = '0, cmp_ch = '0;
  logic [CW-1:0] cfg_acnt = '0, cfg_bcnt = '0, cfg_ccnt = '0;
  logic [NCH-1:0] ev_in = '0, man_set = '0;
  logic rq_ready = 1'b1, cmp_valid = 0, cmp_last = 0;
  logic rq_valid, rq_last, err_int;
  logic [CHW-1:0] rq_ch;
  logic [1:0] rq_kind;
  logic [CW-1:0] rq_acnt, rq_bcnt;
  logic [NCH-1:0] cmp_int, miss_flag;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [EW-1:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  dma_evt_sched i_dma_evt_sched (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic expect_rq(input int ch, input int kind, input bit last,
                           input int a, input int b, input string req);
    exp_q.push_back({CHW'(ch), 2'(kind), last, CW'(a), CW'(b)});
    tag_q.push_back(req);
  endtask

  always @(negedge clk) begin
    if (rst_n && rq_valid && rq_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected request: actual %0h expected none",
                 {rq_ch, rq_kind, rq_last, rq_acnt, rq_bcnt});
      end else begin
        automatic logic [EW-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        automatic logic [EW-1:0] a = {rq_ch, rq_kind, rq_last, rq_acnt, rq_bcnt};
        if (a !== e) begin
          errors++;
          $display("FAIL %s: actual %0h expected %0h", t, a, e);
        end
      end
    end
  end

  task automatic cfg(input int ch, input int a, input int b, input int c,
                     input bit ab, input bit len, input int lch);
    @(negedge clk);
    cfg_we = 1; cfg_ch = CHW'(ch); cfg_acnt = CW'(a); cfg_bcnt = CW'(b);
    cfg_ccnt = CW'(c); cfg_ab = ab; cfg_link_en = len; cfg_link_ch = CHW'(lch);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic man(input logic [NCH-1:0] m);
    @(negedge clk); man_set = m;
    @(negedge clk); man_set = '0;
  endtask

  task automatic ev(input logic [NCH-1:0] m);
    @(negedge clk); ev_in = m;
    @(negedge clk); ev_in = '0;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
    chk("queue drained", 32'(exp_q.size()), 0);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 rq_valid", 32'(rq_valid), 0);
    chk("R1 err_int", 32'(err_int), 0);
    chk("R1 cmp_int", 32'(cmp_int), 0);
    chk("R1 miss_flag", 32'(miss_flag), 0);

    // R2 R4 R7 frame mode then dummy
    cfg(1, 4, 3, 2, 1, 0, 0);
    expect_rq(1, 1, 0, 4, 3, "R4 frame 1");
    man(4'b0010);
    chk("R2 request visible after next edge", 32'(rq_valid), 0);
    @(negedge clk);
    chk("R2 request visible", 32'(rq_valid), 1);
    expect_rq(1, 1, 1, 4, 3, "R4 frame last");
    man(4'b0010);
    expect_rq(1, 2, 0, 4, 3, "R7 dummy");
    man(4'b0010);
    @(negedge clk);
    chk("R7 no error on dummy", 32'(err_int), 0);
    settle();

    // R5 array mode via external events
    cfg(2, 5, 2, 2, 0, 0, 0);
    expect_rq(2, 0, 0, 5, 1, "R5 array 1");
    expect_rq(2, 0, 0, 5, 1, "R5 array 2");
    expect_rq(2, 0, 0, 5, 1, "R5 array 3");
    expect_rq(2, 0, 1, 5, 1, "R5 array last");
    for (int k = 0; k < 4; k++) ev(4'b0100);
    settle();

    // R6 null set
    cfg(0, 0, 0, 0, 0, 0, 0);
    man(4'b0001);
    chk("R6 no error before service", 32'(err_int), 0);
    @(negedge clk);
    chk("R6 error pulse", 32'(err_int), 1);
    @(negedge clk);
    chk("R6 error one cycle", 32'(err_int), 0);
    settle();

    // R3 priority
    cfg(1, 1, 1, 3, 1, 0, 0);
    cfg(3, 7, 2, 3, 1, 0, 0);
    expect_rq(1, 1, 0, 1, 1, "R3 lower channel first");
    expect_rq(3, 1, 0, 7, 2, "R3 higher channel next");
    man(4'b1010);
    settle();

    // R8 R9 full queue, held trigger, missed trigger
    cfg(0, 1, 0, 0, 0, 0, 0);
    rq_ready = 0;
    for (int k = 0; k < 17; k++) begin
      expect_rq(0, 2, 0, 1, 1, "R8 queued dummy in order");
      man(4'b0001);
    end
    @(negedge clk);
    chk("R8 head valid while full", 32'(rq_valid), 1);
    man(4'b0001);
    chk("R9 missed flag set", 32'(miss_flag), 32'h1);
    chk("R9 error on miss", 32'(err_int), 1);
    rq_ready = 1;
    repeat (30) @(negedge clk);
    chk("R8 held trigger issued", 32'(exp_q.size()), 0);
    chk("R9 flag sticky", 32'(miss_flag), 32'h1);
    cfg(0, 1, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk("R9 cleared by config", 32'(miss_flag), 0);

    // R10 R11 completion and link
    cfg(1, 1, 1, 1, 1, 1, 3);
    cfg(3, 2, 2, 1, 1, 0, 0);
    expect_rq(3, 1, 1, 2, 2, "R11 linked request");
    @(negedge clk);
    cmp_valid = 1; cmp_ch = 2'd1; cmp_last = 1;
    @(negedge clk);
    cmp_valid = 0; cmp_last = 0;
    chk("R10 cmp_int one-hot", 32'(cmp_int), 32'h2);
    @(negedge clk);
    chk("R10 cmp_int pulse ends", 32'(cmp_int), 0);
    settle();
    @(negedge clk);
    cmp_valid = 1; cmp_ch = 2'd2; cmp_last = 0;
    @(negedge clk);
    cmp_valid = 0;
    chk("R10 no interrupt without last", 32'(cmp_int), 0);
    settle();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule